// File: doc/BRIEF.md
# Input Clock Loss and Frequency Offset Monitor

This block watches four input clocks from a free-running local reference clock and raises, for each input, an active-high invalid flag that an input selector uses to decide which inputs it may switch to. Every input is brought into the local domain through a synchronizer and reduced to a single-cycle rising-edge pulse. The inputs may run at most at one quarter of the local reference rate.

Two checks feed each flag. The first is a loss-of-signal check. A per-input counter measures the local cycles since the last edge. The timeout is four and a half times a divider ratio times the nominal input period. Once an input is flagged it stays flagged until it has produced a run of consecutive edges with no further timeout. The second is a frequency-offset check. It counts the edges of inputs 1, 3 and 4 over a gate that is a fixed number of edges of input 2. Input 2 is the frequency reference. It then compares each count's distance from the gate length with a ppm-derived threshold. The result is meaningful when all the clocks are integer multiples of 19.44 MHz at the same nominal rate. A three-state mode input turns the offset check off or selects a tight (12 ppm) or a loose (48 ppm) threshold.

The block has no data stream, so it has no valid/ready interface. All its pins are plain level signals. Port bit i stands for input i+1.

Top module: `inclk_monitor`

## Requirements
- R1: While reset is held and right after it is released, all four invalid flags are 1.
- R2: An input with no rising edge for LOS_LIMIT = (9*N3_DIV*PERIOD_REF)/2 local cycles (36 by default) gets its loss flag set. An input that keeps toggling inside that window is not flagged.
- R3: A loss on one input does not change the invalid flag of any other input.
- R4: After a loss, the invalid flag stays 1 when edges return, as long as fewer than QUAL_EDGES (16 by default) consecutive edges have been seen.
- R5: The loss flag clears only on the QUAL_EDGES-th consecutive edge. A gap of LOS_LIMIT cycles restarts that count from zero.
- R6: Offset is measured on bits 0, 2 and 3, and bit 1 is the reference. A gate closes on every GATE_EDGES-th reference edge. Each monitored offset flag is recomputed at the close of each gate. The reference bit never carries an offset flag.
- R7: With ofs_mode = 2'b01 (tight), an input is offset-flagged when |count - GATE_EDGES| > floor(12*GATE_EDGES/FULL_SCALE).
- R8: With ofs_mode = 2'b10 (loose), the threshold is floor(48*GATE_EDGES/FULL_SCALE), so a deviation above the tight threshold but within the loose one is not flagged.
- R9: With ofs_mode = 2'b00 (off) or 2'b11 (reserved, treated as off), the offset flags are masked. One cycle later, invalid equals the loss flags alone, and an offset flag held while masked is not cleared by the masking.
- R10: invalid is registered and equals the OR of the loss flag and the enabled offset flag. An input with regular edges but an out-of-range count is therefore invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_in | input | N_IN (4) | Monitored input clocks, asynchronous to clk |
| ofs_mode | input | 2 | Offset check mode: 00 off, 01 tight, 10 loose, 11 off |
| invalid | output | N_IN (4) | Per-input invalid flags, active high |

## Verification
Every input first runs at the nominal period, which separates healthy inputs from the flags set at reset and shows the qualification run. One input is then silenced, restarted, and silenced again part-way through its qualification. This separates the loss timeout, the sticky flag, and the restart of the consecutive-edge count, while the other inputs show independence. A monitored input with a small deviation (every fourth period one cycle short) is flagged under the tight threshold but not the loose one. A large deviation is flagged under both. A faster reference shows that every monitored input is flagged while the reference bit stays clear. Switching the mode to off or reserved while a flag is held shows the masking.

// File: rtl/inclk_mon_pkg.sv
package inclk_mon_pkg;

  typedef enum logic [1:0] {
    OFS_OFF   = 2'b00,
    OFS_TIGHT = 2'b01,
    OFS_LOOSE = 2'b10,
    OFS_RSVD  = 2'b11
  } ofs_mode_e;

  localparam int PPM_TIGHT = 12;
  localparam int PPM_LOOSE = 48;

  // Threshold in edge counts for a given ppm over a gate of gate edges.
  function automatic int ppm_to_cnt(input int ppm, input int gate, input int scale);
    longint prod;
    prod = longint'(ppm) * longint'(gate);
    return int'(prod / longint'(scale));
  endfunction

endpackage

// File: rtl/inclk_edge_sync.sv
module inclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], raw};
  end

  // One pulse per rising edge, taken after the synchronizer stages.
  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/inclk_los_qual.sv
module inclk_los_qual #(
  parameter int LIMIT      = 36,
  parameter int QUAL_EDGES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic los
);
  localparam int GW = $clog2(LIMIT + 1);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  logic [GW-1:0] gap;
  logic [QW-1:0] qual;
  logic          timeout;
  logic          qual_done;

  assign timeout   = (gap == GW'(LIMIT - 1)) && !rise;
  assign qual_done = rise && (qual == QW'(QUAL_EDGES - 1));

  // Local cycles since the last edge, saturating at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n)                 gap <= '0;
    else if (rise)              gap <= '0;
    else if (gap != GW'(LIMIT)) gap <= gap + 1'b1;
  end

  // Consecutive-edge run, counted only while flagged.
  always_ff @(posedge clk) begin
    if (!rst_n)              qual <= '0;
    else if (!los)           qual <= '0;
    else if (timeout)        qual <= '0;
    else if (qual_done)      qual <= '0;
    else if (rise)           qual <= qual + 1'b1;
  end

  // The flag starts set: an input is invalid until it has been qualified.
  always_ff @(posedge clk) begin
    if (!rst_n)                 los <= 1'b1;
    else if (timeout)           los <= 1'b1;
    else if (los && qual_done)  los <= 1'b0;
  end
endmodule

// File: rtl/inclk_ofs_meter.sv
module inclk_ofs_meter
  import inclk_mon_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int REF_IDX    = 1,
  parameter int GATE_EDGES = 100000,
  parameter int TH_TIGHT   = 1,
  parameter int TH_LOOSE   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] rise,
  input  ofs_mode_e       mode,
  output logic [N_IN-1:0] ofs_flag
);
  localparam int GW = $clog2(GATE_EDGES + 1);
  localparam int CW = $clog2(4 * GATE_EDGES + 2);

  logic [GW-1:0] gate_cnt;
  logic          gate_end;
  logic [CW-1:0] th_sel;

  assign gate_end = rise[REF_IDX] && (gate_cnt == GW'(GATE_EDGES - 1));
  assign th_sel   = (mode == OFS_LOOSE) ? CW'(TH_LOOSE) : CW'(TH_TIGHT);

  always_ff @(posedge clk) begin
    if (!rst_n)             gate_cnt <= '0;
    else if (gate_end)      gate_cnt <= '0;
    else if (rise[REF_IDX]) gate_cnt <= gate_cnt + 1'b1;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_ch
    if (g == REF_IDX) begin : g_ref
      assign ofs_flag[g] = 1'b0;
    end else begin : g_mon
      logic [CW-1:0] cnt;
      logic [CW-1:0] total;
      logic [CW-1:0] dev;
      logic          flag_q;

      assign total = cnt + CW'(rise[g]);
      assign dev   = (total >= CW'(GATE_EDGES)) ? (total - CW'(GATE_EDGES))
                                                : (CW'(GATE_EDGES) - total);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt    <= '0;
          flag_q <= 1'b0;
        end else if (gate_end) begin
          cnt    <= '0;
          flag_q <= (dev > th_sel);
        end else if (rise[g] && (cnt != '1)) begin
          cnt <= cnt + 1'b1;
        end
      end

      assign ofs_flag[g] = flag_q;
    end
  end
endmodule

// File: rtl/inclk_monitor.sv
module inclk_monitor
  import inclk_mon_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int REF_IDX     = 1,
  parameter int PERIOD_REF  = 8,
  parameter int N3_DIV      = 1,
  parameter int QUAL_EDGES  = 16,
  parameter int GATE_EDGES  = 100000,
  parameter int FULL_SCALE  = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] clk_in,
  input  logic [1:0]      ofs_mode,
  output logic [N_IN-1:0] invalid
);
  localparam int LOS_LIMIT = (9 * N3_DIV * PERIOD_REF) / 2;
  localparam int TH_TIGHT  = ppm_to_cnt(PPM_TIGHT, GATE_EDGES, FULL_SCALE);
  localparam int TH_LOOSE  = ppm_to_cnt(PPM_LOOSE, GATE_EDGES, FULL_SCALE);

  logic [N_IN-1:0] rise_v;
  logic [N_IN-1:0] los_v;
  logic [N_IN-1:0] ofs_v;
  ofs_mode_e       mode;
  logic            ofs_en;

  assign mode   = ofs_mode_e'(ofs_mode);
  assign ofs_en = (mode == OFS_TIGHT) || (mode == OFS_LOOSE);

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    inclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (clk_in[g]),
      .rise (rise_v[g])
    );
    inclk_los_qual #(.LIMIT(LOS_LIMIT), .QUAL_EDGES(QUAL_EDGES)) los_i (
      .clk  (clk),
      .rst_n(rst_n),
      .rise (rise_v[g]),
      .los  (los_v[g])
    );
  end

  inclk_ofs_meter #(
    .N_IN      (N_IN),
    .REF_IDX   (REF_IDX),
    .GATE_EDGES(GATE_EDGES),
    .TH_TIGHT  (TH_TIGHT),
    .TH_LOOSE  (TH_LOOSE)
  ) ofs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise_v),
    .mode    (mode),
    .ofs_flag(ofs_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) invalid <= '1;
    else        invalid <= los_v | (ofs_v & {N_IN{ofs_en}});
  end
endmodule

// File: rtl/inclk_monitor_chk.sv
module inclk_monitor_chk #(
  parameter int N_IN    = 4,
  parameter int REF_IDX = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      ofs_mode,
  input logic [N_IN-1:0] rise,
  input logic [N_IN-1:0] los,
  input logic [N_IN-1:0] invalid
);
  AST_LOS_SETS_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((los & ~$past(los) & $past(rise)) == '0)); // R2

  AST_LOS_CLEARS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~los & $past(los) & ~$past(rise)) == '0)); // R5

  AST_LOS_FORCES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((invalid & $past(los)) == $past(los))); // R10

  AST_MASK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ofs_mode) == 2'b00 || $past(ofs_mode) == 2'b11) |-> (invalid == $past(los))); // R9

  AST_REF_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (invalid[REF_IDX] == $past(los[REF_IDX]))); // R6
endmodule

bind inclk_monitor inclk_monitor_chk #(.N_IN(N_IN), .REF_IDX(REF_IDX)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ofs_mode(ofs_mode),
  .rise    (rise_v),
  .los     (los_v),
  .invalid (invalid)
);

// File: tb/inclk_monitor_tb_top.sv
`timescale 1ns/1ps
module inclk_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] clk_in = '0;
  logic [1:0] ofs_mode = 2'b00;
  logic [3:0] invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int per [4];
  bit shrt[4];
  bit run [4];
  int ph  [4];
  int cyc [4];

  always #4 clk = ~clk;

  inclk_monitor #(.GATE_EDGES(100), .FULL_SCALE(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .ofs_mode(ofs_mode), .invalid(invalid)
  );

  // Input clock generator: high for 3 local cycles, optional short 4th period.
  initial begin
    for (int i = 0; i < 4; i++) begin
      per[i] = 8; shrt[i] = 0; run[i] = 0; ph[i] = 0; cyc[i] = 0;
    end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (!run[i]) begin
          clk_in[i] = 1'b0;
          ph[i] = 0;
        end else begin
          int cur;
          cur = (shrt[i] && cyc[i] == 3) ? per[i] - 1 : per[i];
          clk_in[i] = (ph[i] < 3);
          if (ph[i] >= cur - 1) begin
            ph[i] = 0;
            cyc[i] = (cyc[i] + 1) % 4;
          end else begin
            ph[i] = ph[i] + 1;
          end
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [3:0] exp, input string req);
    n_chk++;
    if (invalid !== exp) begin
      n_bad++;
      $display("FAIL %s: invalid actual=%b expected=%b", req, invalid, exp);
    end
  endtask

  task automatic t_reset();
    wait_cyc(2);
    check(4'hF, "R1 invalid during reset");
    rst_n = 1'b1;
    wait_cyc(2);
    check(4'hF, "R1 invalid right after reset");
  endtask

  task automatic t_qualify();
    for (int i = 0; i < 4; i++) run[i] = 1;
    wait_cyc(60);
    check(4'hF, "R4 not yet qualified after ~7 edges");
    wait_cyc(150);
    check(4'h0, "R5 qualified after 16 edges");
  endtask

  task automatic t_los();
    run[2] = 0;
    wait_cyc(20);
    check(4'h0, "R2 no loss inside window");
    wait_cyc(50);
    check(4'b0100, "R2 R3 loss on input 3 only");
    run[2] = 1;
    wait_cyc(80);
    check(4'b0100, "R4 sticky while qualifying");
    run[2] = 0;
    wait_cyc(60);
    run[2] = 1;
    wait_cyc(80);
    check(4'b0100, "R5 gap restarts qualification");
    wait_cyc(100);
    check(4'h0, "R5 cleared after full run");
  endtask

  task automatic t_tight();
    ofs_mode = 2'b01;
    shrt[0] = 1;
    wait_cyc(1800);
    check(4'b0001, "R7 R10 small offset flagged in tight mode");
  endtask

  task automatic t_loose();
    ofs_mode = 2'b10;
    wait_cyc(1800);
    check(4'h0, "R8 small offset within loose threshold");
    per[3] = 6;
    wait_cyc(1800);
    check(4'b1000, "R8 large offset flagged in loose mode");
  endtask

  task automatic t_mask();
    ofs_mode = 2'b00;
    wait_cyc(3);
    check(4'h0, "R9 mode off masks offset");
    ofs_mode = 2'b11;
    wait_cyc(3);
    check(4'h0, "R9 reserved mode masks offset");
    ofs_mode = 2'b10;
    wait_cyc(3);
    check(4'b1000, "R9 held flag returns when unmasked");
  endtask

  task automatic t_ref();
    shrt[0] = 0;
    per[3] = 8;
    per[1] = 6;
    wait_cyc(1800);
    check(4'b1101, "R6 fast reference flags monitored inputs only");
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    t_reset();
    t_qualify();
    t_los();
    t_tight();
    t_loose();
    t_mask();
    t_ref();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule